// File: doc/BRIEF.md
# Slot-Start Qualifier for a Single-Wire Bus Slave

This block sits between the pad of a single-wire open-drain bus and the bit-level decoder of a slave. It takes the raw, already-thresholded line level and passes it through a synchronizer. It then decides which low-going edges really open a new time slot. Ringing and reflections after the master releases the line appear as short low pulses. A hold-off timer that restarts on every synchronized rising edge masks them. At standard speed, a low must also persist for a set number of clocks before it counts, which rejects high-frequency noise. At the fast (overdrive) speed this persistence filter is bypassed, but the hold-off still applies.

Once a slot is accepted, the block emits a one-clock strobe and drives a filtered line level low. It then refuses any further slot start until the slot period for the current speed has elapsed. A low that is still present when the slot period ends is treated as the same low period and never produces a second strobe. All lengths are counted in system clocks, and each speed has its own parameter.

Top module: `slot_start_qualifier`

## Requirements
- R1: While reset is asserted, and after its release until the line is driven low, `slot_start_o` is 0 and `line_filt_o` is 1.
- R2: From an idle state with no hold-off pending, take edge 0 as the first clock edge that samples `bus_raw_i` low. The strobe is then high in the cycle after edge FILT_STD+1 at standard speed, and in the cycle after edge 2 at fast speed.
- R3: At standard speed (`fast_mode_i` = 0), a low lasting fewer than FILT_STD consecutive clocks produces no strobe.
- R4: Take edge 0 as the first edge that samples `bus_raw_i` high after a low. Consider a low sampled from edge D through edge D+G-1. It produces a strobe only if D+G >= HOLD+2, where HOLD is HOLD_STD at standard speed and HOLD_FAST at fast speed. This holds at both speeds.
- R5: A low that starts inside the hold-off window and passes that condition is accepted as a slot start. At edge 0 as in R4, the strobe follows edge max(HOLD+3, D+F+1), where F is FILT_STD at standard speed and 1 at fast speed.
- R6: The strobe is high for exactly one clock, and it rises at most once per low period of the line.
- R7: After a strobe, no new strobe occurs until at least the slot period has passed: SLOT_STD or SLOT_FAST clocks, depending on speed. A low still present when that period ends yields no strobe.
- R8: `line_filt_o` falls only together with a strobe. It rises in the cycle after edge 2, where edge 0 is the first edge that samples `bus_raw_i` high. Rejected lows never appear on it.
- R9: At fast speed, the persistence filter is bypassed (a single sampled low cycle qualifies), and the hold-off uses HOLD_FAST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_raw_i | input | 1 | Thresholded bus level, asynchronous to clk_i |
| fast_mode_i | input | 1 | 1 selects fast (overdrive) timing, 0 selects standard timing |
| slot_start_o | output | 1 | One-clock strobe marking an accepted slot start |
| line_filt_o | output | 1 | Bus level with rejected lows removed |

## Verification
The hardest situation to reach is a low pulse that straddles the end of the hold-off window by exactly one clock. A single cycle separates rejection from acceptance there, and the acceptance edge is set by whichever of the window and the persistence filter finishes later. The stimulus table first forces a long low and a release, so that the rising edge that arms the hold-off lands on a known clock. It then places lows at chosen offsets and lengths just below and just at the D+G = HOLD+2 boundary, at both speeds. For each one it checks both whether a strobe appears and the exact clock on which it appears. Directed runs place lows inside and across the slot lockout to cover R7.

// File: rtl/slot_qual_pkg.sv
package slot_qual_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SLOT   = 2'd1,
    ST_WAITHI = 2'd2
  } qual_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sq_reset_sync.sv
module sq_reset_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/sq_sync.sv
module sq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d_i;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sq_holdoff.sv
module sq_holdoff #(
  parameter int HOLD_STD  = 1250,
  parameter int HOLD_FAST = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic line_i,
  output logic busy_o
);
  localparam int HMAX = slot_qual_pkg::imax(HOLD_STD, HOLD_FAST);
  localparam int HW   = $clog2(HMAX + 1);
  localparam logic [HW-1:0] HLEN_STD  = HW'(HOLD_STD);
  localparam logic [HW-1:0] HLEN_FAST = HW'(HOLD_FAST);

  logic          line_q;
  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en, rise;

  always_comb begin
    rise   = line_i & ~line_q;
    cnt_en = rise | (cnt_q != '0);
    if (rise) cnt_d = fast_i ? HLEN_FAST : HLEN_STD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      line_q <= line_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sq_low_filter.sv
module sq_low_filter #(
  parameter int FILT_STD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic line_i,
  output logic qual_o
);
  generate
    if (FILT_STD <= 1) begin : g_nofilt
      assign qual_o = ~line_i;
    end else begin : g_filt
      localparam int LW = $clog2(FILT_STD);
      localparam logic [LW-1:0] SAT = LW'(FILT_STD - 1);

      logic [LW-1:0] low_q, low_d;
      logic          low_en;

      always_comb begin
        if (line_i) begin
          low_d  = '0;
          low_en = (low_q != '0);
        end else begin
          low_d  = low_q + 1'b1;
          low_en = (low_q != SAT);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     low_q <= '0;
        else if (low_en) low_q <= low_d;
      end

      // fast speed bypasses the persistence requirement
      assign qual_o = ~line_i & (fast_i | (low_q == SAT));
    end
  endgenerate
endmodule

// File: rtl/sq_slot_fsm.sv
module sq_slot_fsm
  import slot_qual_pkg::*;
#(
  parameter int SLOT_STD  = 15000,
  parameter int SLOT_FAST = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  input  logic line_i,
  input  logic qual_i,
  input  logic hold_busy_i,
  output logic strobe_o,
  output logic filt_o
);
  localparam int SMAX = imax(SLOT_STD, SLOT_FAST);
  localparam int SW   = $clog2(SMAX + 1);
  localparam logic [SW-1:0] SLAST_STD  = SW'(SLOT_STD - 1);
  localparam logic [SW-1:0] SLAST_FAST = SW'(SLOT_FAST - 1);

  qual_state_e   state_q, state_d;
  logic [SW-1:0] cnt_q, cnt_d, slot_last;
  logic          cnt_en;
  logic          strobe_q, strobe_d;
  logic          filt_q, filt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + 1'b1;
    cnt_en    = 1'b0;
    strobe_d  = 1'b0;
    filt_d    = filt_q;
    slot_last = fast_i ? SLAST_FAST : SLAST_STD;
    case (state_q)
      ST_IDLE: begin
        if (qual_i && !hold_busy_i) begin
          state_d  = ST_SLOT;
          cnt_d    = '0;
          cnt_en   = 1'b1;
          strobe_d = 1'b1;
          filt_d   = 1'b0;
        end
      end
      ST_SLOT: begin
        cnt_en = 1'b1;
        if (line_i) filt_d = 1'b1;
        if (cnt_q >= slot_last) state_d = line_i ? ST_IDLE : ST_WAITHI;
      end
      ST_WAITHI: begin
        if (line_i) begin
          state_d = ST_IDLE;
          filt_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      filt_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_d;
      filt_q   <= filt_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign strobe_o = strobe_q;
  assign filt_o   = filt_q;
endmodule

// File: rtl/slot_start_qualifier.sv
module slot_start_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STD    = 16,
  parameter int HOLD_STD    = 1250,
  parameter int HOLD_FAST   = 500,
  parameter int SLOT_STD    = 15000,
  parameter int SLOT_FAST   = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_raw_i,
  input  logic fast_mode_i,
  output logic slot_start_o,
  output logic line_filt_o
);
  logic rst_n_int;
  logic line_s;
  logic hold_busy;
  logic low_qual;

  sq_reset_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  sq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (bus_raw_i),
    .q_o    (line_s)
  );

  sq_holdoff #(.HOLD_STD(HOLD_STD), .HOLD_FAST(HOLD_FAST)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .fast_i (fast_mode_i),
    .line_i (line_s),
    .busy_o (hold_busy)
  );

  sq_low_filter #(.FILT_STD(FILT_STD)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .fast_i (fast_mode_i),
    .line_i (line_s),
    .qual_o (low_qual)
  );

  sq_slot_fsm #(.SLOT_STD(SLOT_STD), .SLOT_FAST(SLOT_FAST)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .fast_i      (fast_mode_i),
    .line_i      (line_s),
    .qual_i      (low_qual),
    .hold_busy_i (hold_busy),
    .strobe_o    (slot_start_o),
    .filt_o      (line_filt_o)
  );
endmodule

// File: rtl/slot_start_qualifier_chk.sv
module slot_start_qualifier_chk #(
  parameter int FILT_STD  = 16,
  parameter int SLOT_STD  = 15000,
  parameter int SLOT_FAST = 1500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fast_mode_i,
  input logic slot_start_o,
  input logic line_filt_o,
  input logic line_s,
  input logic hold_busy
);
  localparam int SMIN = slot_qual_pkg::imin(SLOT_STD, SLOT_FAST);
  localparam int GMAX = slot_qual_pkg::imax(SLOT_STD, SLOT_FAST) + 1;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int RW   = $clog2(FILT_STD + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(GMAX);
  localparam logic [GW-1:0] GAP_MIN = GW'(SMIN);
  localparam logic [RW-1:0] RUN_SAT = RW'(FILT_STD);

  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;

  // independent counters observed by the properties below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_SAT;
      run_q <= '0;
    end else begin
      if (slot_start_o)         gap_q <= GW'(1);
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
      if (line_s)               run_q <= '0;
      else if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
    end
  end

  assert_std_filter_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_o && !$past(fast_mode_i)) |-> (run_q >= RUN_SAT));

  assert_holdoff_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> !$past(hold_busy));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |=> !slot_start_o);

  assert_slot_lockout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> (gap_q > GAP_MIN));

  assert_filt_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_filt_o) |-> slot_start_o);
endmodule

bind slot_start_qualifier slot_start_qualifier_chk #(
  .FILT_STD  (FILT_STD),
  .SLOT_STD  (SLOT_STD),
  .SLOT_FAST (SLOT_FAST)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fast_mode_i  (fast_mode_i),
  .slot_start_o (slot_start_o),
  .line_filt_o  (line_filt_o),
  .line_s       (line_s),
  .hold_busy    (hold_busy)
);

// File: tb/slot_start_qualifier_test.sv
module slot_start_qualifier_test;
  localparam int F  = 4;
  localparam int HS = 12;
  localparam int HF = 6;
  localparam int SS = 40;
  localparam int SF = 16;

  logic clk, rst_ni, raw, fast;
  logic strobe, filt;
  int   checks, errors;
  bit   done;

  slot_start_qualifier #(
    .SYNC_STAGES(2), .FILT_STD(F), .HOLD_STD(HS), .HOLD_FAST(HF),
    .SLOT_STD(SS), .SLOT_FAST(SF)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_raw_i(raw), .fast_mode_i(fast),
    .slot_start_o(strobe), .line_filt_o(filt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {fast, D, G, expect}: low at edges D..D+G-1 after the release edge
  localparam logic [17:0] VECS [0:11] = '{
    {1'b0, 8'd3,  8'd5,  1'b0},
    {1'b0, 8'd5,  8'd8,  1'b0},
    {1'b0, 8'd5,  8'd9,  1'b1},
    {1'b0, 8'd20, 8'd3,  1'b0},
    {1'b0, 8'd20, 8'd4,  1'b1},
    {1'b0, 8'd2,  8'd30, 1'b1},
    {1'b0, 8'd8,  8'd5,  1'b0},
    {1'b1, 8'd2,  8'd5,  1'b0},
    {1'b1, 8'd2,  8'd6,  1'b1},
    {1'b1, 8'd10, 8'd1,  1'b1},
    {1'b1, 8'd3,  8'd4,  1'b0},
    {1'b1, 8'd8,  8'd5,  1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_vec(input logic f, input int d, input int g, input bit exp);
    int cnt, first, fe, hold, t, filt_min, filt2, filt3;
    string tag;
    fast = f;
    raw  = 1'b1;
    repeat (60) @(negedge clk);
    // long low: one strobe, fixed latency (R2, R6, R7)
    raw = 1'b0; cnt = 0; first = -1;
    for (int n = 1; n <= 50; n++) begin
      @(negedge clk);
      if (strobe) begin cnt++; if (first < 0) first = n; end
      if (n == 50) raw = 1'b1;
    end
    fe = f ? 1 : F;
    check(first == fe + 2, "R2 strobe latency", first, fe + 2);
    check(cnt == 1, "R6 one strobe per low", cnt, 1);
    // release, then a low placed relative to the hold-off window
    hold = f ? HF : HS;
    cnt = 0; first = -1; filt_min = 1; filt2 = -1; filt3 = -1;
    for (int n = 1; n <= 150; n++) begin
      @(negedge clk);
      if (strobe) begin cnt++; if (first < 0) first = n; end
      if (n == 2) filt2 = filt;
      if (n == 3) filt3 = filt;
      if (n >= 3 && !filt) filt_min = 0;
      if (n == d) raw = 1'b0;
      if (n == d + g) raw = 1'b1;
    end
    tag = (g < fe) ? "R3 filter" : (f ? "R9 fast hold-off" : "R4 hold-off");
    check(cnt == int'(exp), tag, cnt, int'(exp));
    check(filt2 == 0 && filt3 == 1, "R8 filtered rise", filt3, 1);
    if (exp) begin
      t = (hold + 3 > d + fe + 1) ? hold + 3 : d + fe + 1;
      check(first == t + 1, "R5 late low accept", first, t + 1);
    end else begin
      check(filt_min == 1, "R8 rejected low hidden", filt_min, 1);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_ni = 1'b0; raw = 1'b1; fast = 1'b0;
    repeat (3) @(negedge clk);
    check(strobe == 1'b0, "R1 reset strobe", strobe, 0);
    check(filt == 1'b1, "R1 reset filt", filt, 1);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    check(strobe == 1'b0 && filt == 1'b1, "R1 after release", filt, 1);

    for (int i = 0; i < 12; i++)
      run_vec(VECS[i][17], int'(VECS[i][16:9]), int'(VECS[i][8:1]), VECS[i][0]);

    // R7: low inside the slot period is not a slot
    begin
      int cnt, s1, s2, fmid;
      fast = 1'b0; raw = 1'b1;
      repeat (80) @(negedge clk);
      raw = 1'b0; cnt = 0; s1 = -1; s2 = -1; fmid = -1;
      for (int n = 1; n <= 120; n++) begin
        @(negedge clk);
        if (strobe) begin cnt++; if (s1 < 0) s1 = n; s2 = n; end
        if (n == 30) fmid = filt;
        if (n == 6) raw = 1'b1;
        if (n == 25) raw = 1'b0;
        if (n == 35) raw = 1'b1;
        if (n == 60) raw = 1'b0;
        if (n == 68) raw = 1'b1;
      end
      check(cnt == 2, "R7 lockout count", cnt, 2);
      check(s1 == 6 && s2 == 66, "R7 lockout timing", s2, 66);
      check(fmid == 1, "R8 low in slot hidden", fmid, 1);
    end

    // R7: low spanning the slot end gives no second strobe
    begin
      int cnt, s1, s2;
      raw = 1'b1;
      repeat (80) @(negedge clk);
      raw = 1'b0; cnt = 0; s1 = -1; s2 = -1;
      for (int n = 1; n <= 140; n++) begin
        @(negedge clk);
        if (strobe) begin cnt++; if (s1 < 0) s1 = n; s2 = n; end
        if (n == 6) raw = 1'b1;
        if (n == 40) raw = 1'b0;
        if (n == 60) raw = 1'b1;
        if (n == 90) raw = 1'b0;
        if (n == 96) raw = 1'b1;
      end
      check(cnt == 2, "R7 span count", cnt, 2);
      check(s1 == 6 && s2 == 96, "R7 span timing", s2, 96);
    end

    // R1: reset during an accepted low restores idle outputs
    fast = 1'b1; raw = 1'b1;
    repeat (40) @(negedge clk);
    raw = 1'b0;
    repeat (3) @(negedge clk);
    check(strobe == 1'b1 && filt == 1'b0, "R9 fast strobe", strobe, 1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(filt == 1'b1 && strobe == 1'b0, "R1 reset mid-slot", filt, 1);
    raw = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(filt == 1'b1 && strobe == 1'b0, "R1 idle after reset", filt, 1);

    finish_run();
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end
endmodule